// File: doc/BRIEF.md
# DRAM Page and Refresh Controller

This block drives the command side of an embedded DRAM made of several independent sub-array banks. It takes single read or write requests (bank, row, column) from an upstream buffer interface and turns them into bank commands: activate, close, read, write and refresh. It remembers one open row per bank. A request that lands on the open row of an idle bank is accepted in the same cycle. A request to a closed bank first activates the row and waits out the activation time. A request to a different row of an open bank closes that bank and then reopens it on the new row.

Each data command moves one 256-bit stride as two 128-bit halves. This keeps its bank occupied for a fixed number of core cycles. Other banks stay available during that time, so several transfers can be in flight across different banks.

Refresh runs on a fixed schedule. The interval is a base cycle count shifted left by a rate-select input, and the base is set so that every row is revisited well inside the 32 ms retention window. When a refresh falls due, the controller stops accepting requests. It lets the transfers in flight drain, closes every open bank, and then issues one refresh command for the next row in sequence. A requester that sees ready low must hold its request unchanged until it is accepted.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, `cmd_valid` is low, `req_ready` is low, and every bank is closed, so the first access to any bank starts with an activate.
- R2: A request whose row equals the open row of an idle bank sees `req_ready` high in the same cycle. In the next cycle it appears as one command with `cmd_op` = 3 (read) or 4 (write), carrying the request's bank, row and column.
- R3: A request to a closed bank produces an activate (`cmd_op` = 1) for its bank and row. `req_ready` stays low until the activation time has passed. The data command follows exactly ACT_CYCLES+1 cycles after the activate, and never sooner.
- R4: A request to a bank that is open on another row produces a close (`cmd_op` = 2) for that bank, then an activate in the next cycle, then the data command. No activate is issued to a bank that is still open.
- R5: A data command occupies its bank for XFER_CYCLES cycles. A request to that bank stalls until the occupancy ends, while requests to other banks are still accepted, so back-to-back data commands to one bank are exactly XFER_CYCLES cycles apart.
- R6: With no traffic, refresh commands (`cmd_op` = 5) are issued exactly REF_BASE << `rate_sel` cycles apart.
- R7: Refresh commands carry bank 0 and a row number that starts at 0 after reset and increases by one with each refresh, wrapping at 2^ROW_W.
- R8: Before a refresh, the controller waits for all transfers in flight to finish and closes every open bank, lowest bank number first. After the refresh, every bank is closed and the next access to it needs a new activate.
- R9: While a refresh is pending or in progress, `req_ready` is low. A held request is served once the refresh command has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | RATE_W | Refresh rate select; interval = REF_BASE << rate_sel |
| req_valid | input | 1 | Request present; held stable until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row (page) |
| req_col | input | COL_W | Stride column within the page |
| req_ready | output | 1 | Request accepted at this clock edge |
| cmd_valid | output | 1 | A bank command is issued this cycle |
| cmd_op | output | 3 | 1 activate, 2 close, 3 read, 4 write, 5 refresh |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row of the command (refresh row for refresh) |
| cmd_col | output | COL_W | Column of a read or write |

## Verification
The hardest case to reach from the ports is a refresh that falls due while banks are open and data is still flowing. Only then does the drain-and-close path run before the refresh command. The stimulus opens all four banks and then rotates hit requests over them on consecutive cycles, so that each bank is busy in turn and no same-bank stall occurs. It keeps going until one request is held off. For that request, the bench checks that closes, a refresh, a fresh activate and finally the data command appear in that order.

// File: rtl/dpc_pkg.sv
// Shared types for the DRAM page and refresh controller.
package dpc_pkg;

    // Bank command codes presented on cmd_op.
    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_CLOSE = 3'd2,
        CMD_RD    = 3'd3,
        CMD_WR    = 3'd4,
        CMD_REF   = 3'd5
    } dram_cmd_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACT     = 2'd1,
        ST_WAIT    = 2'd2,
        ST_REFRESH = 2'd3
    } seq_state_e;

endpackage

// File: rtl/dpc_bank_track.sv
// Per-bank bookkeeping: open flag, open row and transfer occupancy counter.
// Assumes the sequencer never raises close_i and act_i together.
module dpc_bank_track #(
    parameter int ROW_W       = 10,
    parameter int XFER_CYCLES = 4,
    localparam int XFER_W     = $clog2(XFER_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             close_i,
    input  logic             xfer_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             busy_o
);
    logic [XFER_W-1:0] occ_q;

    // Track whether a page is open and which row it holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            row_o  <= '0;
        end else if (close_i) begin
            open_o <= 1'b0;
        end else if (act_i) begin
            open_o <= 1'b1;
            row_o  <= row_i;
        end
    end

    // Count down the cycles a double-pumped stride keeps the bank occupied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else if (xfer_i) begin
            occ_q <= XFER_W'(XFER_CYCLES - 1);
        end else if (occ_q != '0) begin
            occ_q <= occ_q - 1'b1;
        end
    end

    assign busy_o = (occ_q != '0);

endmodule

// File: rtl/dpc_refresh_timer.sv
// Free-running refresh interval timer. Emits a one-cycle tick every
// REF_BASE << rate_sel cycles. Assumes REF_BASE >= 2.
module dpc_refresh_timer #(
    parameter int REF_BASE = 256,
    parameter int RATE_W   = 2,
    localparam int MAX_INT = REF_BASE << ((1 << RATE_W) - 1),
    localparam int CNT_W   = $clog2(MAX_INT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              tick_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Interval selected by the rate setting.
    always_comb limit = CNT_W'(REF_BASE) << rate_sel;

    // Count to the interval, wrap and pulse the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q >= limit - CNT_W'(1)) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

endmodule

// File: rtl/dpc_seq.sv
// Command sequencer: decides hit / activate / close-then-activate for each
// request, runs the refresh drain-close-refresh sequence, and registers the
// issued command. Assumes the requester holds a stalled request stable and
// ACT_CYCLES >= 1.
module dpc_seq #(
    parameter int NUM_BANKS  = 4,
    parameter int ROW_W      = 10,
    parameter int COL_W      = 6,
    parameter int ACT_CYCLES = 2,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int WAIT_W    = $clog2(ACT_CYCLES + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic                            req_write,
    input  logic [BANK_W-1:0]               req_bank,
    input  logic [ROW_W-1:0]                req_row,
    input  logic [COL_W-1:0]                req_col,
    input  logic                            ref_tick,
    input  logic [NUM_BANKS-1:0]            bank_open,
    input  logic [NUM_BANKS-1:0]            bank_busy,
    input  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row,
    output logic                            req_ready,
    output logic [NUM_BANKS-1:0]            act_stb,
    output logic [NUM_BANKS-1:0]            close_stb,
    output logic [NUM_BANKS-1:0]            xfer_stb,
    output logic                            cmd_valid,
    output dpc_pkg::dram_cmd_e              cmd_op,
    output logic [BANK_W-1:0]               cmd_bank,
    output logic [ROW_W-1:0]                cmd_row,
    output logic [COL_W-1:0]                cmd_col
);
    import dpc_pkg::*;

    seq_state_e        state_q, state_n;
    logic [WAIT_W-1:0] wait_q, wait_n;
    logic              rf_pend_q, rf_clr;
    logic [ROW_W-1:0]  ref_row_q;
    logic              hit, sel_busy;
    logic [BANK_W-1:0] low_open;

    logic              cv_n;
    dram_cmd_e         op_n;
    logic [BANK_W-1:0] bank_n;
    logic [ROW_W-1:0]  row_n;
    logic [COL_W-1:0]  col_n;

    // Page-hit and occupancy lookup for the requested bank.
    always_comb begin
        hit      = bank_open[req_bank] && (bank_row[req_bank] == req_row);
        sel_busy = bank_busy[req_bank];
    end

    // Lowest-numbered open bank, closed first during refresh.
    always_comb begin
        low_open = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (bank_open[i]) low_open = BANK_W'(i);
        end
    end

    // Accept only page hits on idle banks with no refresh due.
    assign req_ready = (state_q == ST_IDLE) && !rf_pend_q && req_valid && hit && !sel_busy;

    // Next-state, command and bank strobe decision.
    always_comb begin
        state_n   = state_q;
        wait_n    = wait_q;
        rf_clr    = 1'b0;
        cv_n      = 1'b0;
        op_n      = CMD_NOP;
        bank_n    = cmd_bank;
        row_n     = cmd_row;
        col_n     = cmd_col;
        act_stb   = '0;
        close_stb = '0;
        xfer_stb  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (rf_pend_q) begin
                    state_n = ST_REFRESH;
                end else if (req_valid && !sel_busy) begin
                    bank_n = req_bank;
                    row_n  = req_row;
                    cv_n   = 1'b1;
                    if (hit) begin
                        op_n               = req_write ? CMD_WR : CMD_RD;
                        col_n              = req_col;
                        xfer_stb[req_bank] = 1'b1;
                    end else if (bank_open[req_bank]) begin
                        op_n                = CMD_CLOSE;
                        close_stb[req_bank] = 1'b1;
                        state_n             = ST_ACT;
                    end else begin
                        op_n              = CMD_ACT;
                        act_stb[req_bank] = 1'b1;
                        wait_n            = WAIT_W'(ACT_CYCLES - 1);
                        state_n           = ST_WAIT;
                    end
                end
            end
            ST_ACT: begin
                cv_n              = 1'b1;
                op_n              = CMD_ACT;
                bank_n            = req_bank;
                row_n             = req_row;
                act_stb[req_bank] = 1'b1;
                wait_n            = WAIT_W'(ACT_CYCLES - 1);
                state_n           = ST_WAIT;
            end
            ST_WAIT: begin
                if (wait_q == '0) state_n = ST_IDLE;
                else              wait_n  = wait_q - 1'b1;
            end
            ST_REFRESH: begin
                if (|bank_busy) begin
                    state_n = ST_REFRESH;
                end else if (|bank_open) begin
                    cv_n                = 1'b1;
                    op_n                = CMD_CLOSE;
                    bank_n              = low_open;
                    close_stb[low_open] = 1'b1;
                end else begin
                    cv_n    = 1'b1;
                    op_n    = CMD_REF;
                    bank_n  = '0;
                    row_n   = ref_row_q;
                    rf_clr  = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Sequencer state and activation wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wait_q  <= '0;
        end else begin
            state_q <= state_n;
            wait_q  <= wait_n;
        end
    end

    // Refresh pending flag and refresh row pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_pend_q <= 1'b0;
            ref_row_q <= '0;
        end else begin
            if (ref_tick)    rf_pend_q <= 1'b1;
            else if (rf_clr) rf_pend_q <= 1'b0;
            if (rf_clr)      ref_row_q <= ref_row_q + 1'b1;
        end
    end

    // Registered command outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_op    <= CMD_NOP;
            cmd_bank  <= '0;
            cmd_row   <= '0;
            cmd_col   <= '0;
        end else begin
            cmd_valid <= cv_n;
            cmd_op    <= op_n;
            cmd_bank  <= bank_n;
            cmd_row   <= row_n;
            cmd_col   <= col_n;
        end
    end

endmodule

// File: rtl/dram_page_ctrl.sv
// DRAM page and refresh controller top: one open-page tracker per bank, a
// refresh interval timer and the command sequencer. Assumes the requester
// holds a stalled request stable until req_ready is seen high.
module dram_page_ctrl #(
    parameter int NUM_BANKS   = 4,
    parameter int ROW_W       = 10,
    parameter int COL_W       = 6,
    parameter int ACT_CYCLES  = 2,
    parameter int XFER_CYCLES = 4,
    parameter int REF_BASE    = 256,
    parameter int RATE_W      = 2,
    localparam int BANK_W     = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_ready,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col
);
    import dpc_pkg::*;

    logic [NUM_BANKS-1:0]            bank_open, bank_busy;
    logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
    logic [NUM_BANKS-1:0]            act_stb, close_stb, xfer_stb;
    logic                            ref_tick;
    dram_cmd_e                       op_e;

    // One tracker per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dpc_bank_track #(
            .ROW_W      (ROW_W),
            .XFER_CYCLES(XFER_CYCLES)
        ) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .act_i  (act_stb[b]),
            .close_i(close_stb[b]),
            .xfer_i (xfer_stb[b]),
            .row_i  (req_row),
            .open_o (bank_open[b]),
            .row_o  (bank_row[b]),
            .busy_o (bank_busy[b])
        );
    end

    dpc_refresh_timer #(
        .REF_BASE(REF_BASE),
        .RATE_W  (RATE_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_sel(rate_sel),
        .tick_o  (ref_tick)
    );

    dpc_seq #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .COL_W     (COL_W),
        .ACT_CYCLES(ACT_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_bank (req_bank),
        .req_row  (req_row),
        .req_col  (req_col),
        .ref_tick (ref_tick),
        .bank_open(bank_open),
        .bank_busy(bank_busy),
        .bank_row (bank_row),
        .req_ready(req_ready),
        .act_stb  (act_stb),
        .close_stb(close_stb),
        .xfer_stb (xfer_stb),
        .cmd_valid(cmd_valid),
        .cmd_op   (op_e),
        .cmd_bank (cmd_bank),
        .cmd_row  (cmd_row),
        .cmd_col  (cmd_col)
    );

    assign cmd_op = op_e;

endmodule

// File: rtl/dpc_checker.sv
// Protocol checker for dram_page_ctrl. Keeps a shadow of each bank's open
// state and cycle counts since its last activate and data command, built only
// from the command outputs.
module dpc_checker #(
    parameter int NUM_BANKS   = 4,
    parameter int ROW_W       = 10,
    parameter int COL_W       = 6,
    parameter int ACT_CYCLES  = 2,
    parameter int XFER_CYCLES = 4,
    localparam int BANK_W     = $clog2(NUM_BANKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [BANK_W-1:0] req_bank,
    input logic [ROW_W-1:0]  req_row,
    input logic [COL_W-1:0]  req_col,
    input logic              req_ready,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [ROW_W-1:0]  cmd_row,
    input logic [COL_W-1:0]  cmd_col
);
    import dpc_pkg::*;

    localparam logic [7:0] ACT_MIN  = 8'(ACT_CYCLES + 1);
    localparam logic [7:0] XFER_MIN = 8'(XFER_CYCLES);

    logic is_data, is_act, is_close, is_ref;
    assign is_data  = cmd_valid && (cmd_op == CMD_RD || cmd_op == CMD_WR);
    assign is_act   = cmd_valid && (cmd_op == CMD_ACT);
    assign is_close = cmd_valid && (cmd_op == CMD_CLOSE);
    assign is_ref   = cmd_valid && (cmd_op == CMD_REF);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        logic [7:0]       since_act, since_xfer;
        logic             sh_open;
        logic [ROW_W-1:0] sh_row;
        logic             sel;
        assign sel = (cmd_bank == BANK_W'(b));

        // Shadow open state and saturating cycle counters for this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                since_act  <= 8'hFF;
                since_xfer <= 8'hFF;
                sh_open    <= 1'b0;
                sh_row     <= '0;
            end else begin
                if (is_act && sel)           since_act <= 8'd1;
                else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
                if (is_data && sel)           since_xfer <= 8'd1;
                else if (since_xfer != 8'hFF) since_xfer <= since_xfer + 8'd1;
                if (is_act && sel) begin
                    sh_open <= 1'b1;
                    sh_row  <= cmd_row;
                end else if (is_close && sel) begin
                    sh_open <= 1'b0;
                end
            end
        end

        // R3: data only after the activation time has passed.
        a_r3_act_settle: assert property (@(posedge clk) disable iff (!rst_n)
            (is_data && sel) |-> (since_act >= ACT_MIN));

        // R4: data targets the row currently open in its bank.
        a_r4_open_row: assert property (@(posedge clk) disable iff (!rst_n)
            (is_data && sel) |-> (sh_open && sh_row == cmd_row));

        // R4: no activate on a bank that is still open.
        a_r4_close_first: assert property (@(posedge clk) disable iff (!rst_n)
            (is_act && sel) |-> !sh_open);

        // R5: same-bank data commands are at least XFER_CYCLES apart.
        a_r5_bank_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            (is_data && sel) |-> (since_xfer >= XFER_MIN));

        // R8: refresh only with this bank closed and its transfer finished.
        a_r8_ref_clean: assert property (@(posedge clk) disable iff (!rst_n)
            is_ref |-> (!sh_open && since_xfer >= XFER_MIN));
    end

    // R2: an accepted request appears as its data command in the next cycle.
    a_r2_accept_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (is_data && cmd_bank == $past(req_bank)
            && cmd_row == $past(req_row) && cmd_col == $past(req_col)
            && ((cmd_op == CMD_WR) == $past(req_write))));

    // R9: ready stays low while a page switch or refresh close is under way.
    a_r9_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act || is_close) |-> !req_ready);

endmodule

bind dram_page_ctrl dpc_checker #(
    .NUM_BANKS  (NUM_BANKS),
    .ROW_W      (ROW_W),
    .COL_W      (COL_W),
    .ACT_CYCLES (ACT_CYCLES),
    .XFER_CYCLES(XFER_CYCLES)
) u_dpc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_bank (req_bank),
    .req_row  (req_row),
    .req_col  (req_col),
    .req_ready(req_ready),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_bank (cmd_bank),
    .cmd_row  (cmd_row),
    .cmd_col  (cmd_col)
);

// File: tb/dram_page_ctrl_bench.sv
// Directed bench for dram_page_ctrl: one task per scenario, commands logged
// from the ports at each falling edge.
module dram_page_ctrl_bench;
    localparam int NB     = 4;
    localparam int ROW_W  = 10;
    localparam int COL_W  = 6;
    localparam int ACT_C  = 2;
    localparam int XFER_C = 4;
    localparam int RBASE  = 256;
    localparam int BANK_W = 2;

    localparam int OP_ACT = 1, OP_CLOSE = 2, OP_RD = 3, OP_WR = 4, OP_REF = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       rate_sel = 2'd3;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             req_ready;
    logic             cmd_valid;
    logic [2:0]       cmd_op;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    int log_op[64];
    int log_bank[64];
    int log_row[64];
    int log_col[64];
    int log_cyc[64];
    int nlog = 0;

    dram_page_ctrl #(
        .NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .ACT_CYCLES(ACT_C),
        .XFER_CYCLES(XFER_C), .REF_BASE(RBASE), .RATE_W(2)
    ) u_dram_page_ctrl (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
        .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_ready(req_ready),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Command log taken from the ports.
    always @(negedge clk) begin
        if (rst_n && cmd_valid && nlog < 64) begin
            log_op[nlog]   = int'(cmd_op);
            log_bank[nlog] = int'(cmd_bank);
            log_row[nlog]  = int'(cmd_row);
            log_col[nlog]  = int'(cmd_col);
            log_cyc[nlog]  = cyc;
            nlog           = nlog + 1;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] rs);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        rate_sel = rs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        nlog = 0;
    endtask

    task automatic do_req(input logic wr, input int b, input int row, input int col,
                          output int waited, output int acc);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_bank  = BANK_W'(b);
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        #1;
        waited = 0;
        while (!req_ready && waited < 5000) begin
            @(negedge clk);
            #1;
            waited++;
        end
        @(posedge clk);
        #1;
        acc = cyc;
        req_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // R1: reset state.
    task automatic t_reset;
        int w, a;
        do_reset(2'd3);
        settle(1);
        check(!cmd_valid, "R1 cmd_valid after reset", int'(cmd_valid), 0);
        check(!req_ready, "R1 req_ready after reset", int'(req_ready), 0);
        nlog = 0;
        do_req(1'b0, 3, 1, 0, w, a);
        settle(1);
        check(nlog >= 1 && log_op[0] == OP_ACT, "R1 first access activates", log_op[0], OP_ACT);
    endtask

    // R3: closed bank, then R2 hit on the same row.
    task automatic t_closed_then_hit;
        int w, a;
        do_reset(2'd3);
        do_req(1'b0, 1, 5, 3, w, a);
        settle(1);
        check(nlog == 2, "R3 command count", nlog, 2);
        check(log_op[0] == OP_ACT && log_bank[0] == 1 && log_row[0] == 5, "R3 activate bank/row", log_op[0], OP_ACT);
        check(log_op[1] == OP_RD && log_col[1] == 3, "R3 read follows", log_op[1], OP_RD);
        check(log_cyc[1] - log_cyc[0] == ACT_C + 1, "R3 activate-to-read gap", log_cyc[1] - log_cyc[0], ACT_C + 1);
        settle(XFER_C + 1);
        nlog = 0;
        do_req(1'b1, 1, 5, 7, w, a);
        settle(1);
        check(w == 0, "R2 hit accepted at once", w, 0);
        check(nlog == 1 && log_op[0] == OP_WR && log_bank[0] == 1 && log_row[0] == 5 && log_col[0] == 7,
              "R2 write command fields", log_op[0], OP_WR);
        check(log_cyc[0] == a, "R2 command in cycle after accept", log_cyc[0], a);
        // R4: miss on the same bank.
        settle(XFER_C + 1);
        nlog = 0;
        do_req(1'b0, 1, 9, 2, w, a);
        settle(1);
        check(nlog == 3, "R4 command count", nlog, 3);
        check(log_op[0] == OP_CLOSE && log_bank[0] == 1, "R4 close first", log_op[0], OP_CLOSE);
        check(log_op[1] == OP_ACT && log_row[1] == 9 && log_cyc[1] - log_cyc[0] == 1, "R4 activate next cycle", log_op[1], OP_ACT);
        check(log_op[2] == OP_RD && log_cyc[2] - log_cyc[1] == ACT_C + 1, "R4 read after activate", log_cyc[2] - log_cyc[1], ACT_C + 1);
    endtask

    // R5: bank occupancy and parallel banks.
    task automatic t_occupancy;
        int w0, w1, w2, a0, a1, a2;
        do_reset(2'd3);
        do_req(1'b0, 0, 2, 0, w0, a0);
        do_req(1'b0, 1, 2, 0, w0, a0);
        settle(XFER_C + 2);
        nlog = 0;
        do_req(1'b0, 0, 2, 10, w0, a0);
        do_req(1'b0, 1, 2, 11, w1, a1);
        do_req(1'b0, 0, 2, 12, w2, a2);
        settle(1);
        check(w1 == 0, "R5 other bank accepted while busy", w1, 0);
        check(w2 > 0, "R5 same bank stalls", w2, 2);
        check(a2 - a0 == XFER_C, "R5 same-bank spacing", a2 - a0, XFER_C);
        check(nlog == 3 && log_bank[2] == 0 && log_col[2] == 12, "R5 stalled read issued", log_col[2], 12);
    endtask

    // R8: refresh closes open banks lowest first.
    task automatic t_refresh_close;
        int w, a, ref_at;
        do_reset(2'd0);
        do_req(1'b0, 2, 7, 0, w, a);
        do_req(1'b0, 0, 3, 0, w, a);
        settle(XFER_C + 2);
        nlog = 0;
        ref_at = -1;
        for (int i = 0; i < 400 && ref_at < 0; i++) begin
            settle(1);
            for (int k = 0; k < nlog; k++) if (log_op[k] == OP_REF) ref_at = k;
        end
        check(ref_at == 2, "R8 refresh after two closes", ref_at, 2);
        check(log_op[0] == OP_CLOSE && log_bank[0] == 0, "R8 close bank 0 first", log_bank[0], 0);
        check(log_op[1] == OP_CLOSE && log_bank[1] == 2, "R8 close bank 2 second", log_bank[1], 2);
        check(log_row[2] == 0 && log_bank[2] == 0, "R7 first refresh row", log_row[2], 0);
        nlog = 0;
        do_req(1'b0, 0, 3, 1, w, a);
        settle(1);
        check(log_op[0] == OP_ACT && log_bank[0] == 0, "R8 bank reopened after refresh", log_op[0], OP_ACT);
    endtask

    // R6 and R7: refresh spacing and row sequence.
    task automatic t_refresh_rate(input logic [1:0] rs, input int nref);
        int cnt;
        int cycs[4];
        int rows[4];
        do_reset(rs);
        cnt = 0;
        for (int i = 0; i < (RBASE << rs) * (nref + 1) && cnt < nref; i++) begin
            settle(1);
            if (nlog > 0) begin
                if (log_op[nlog-1] == OP_REF && cnt < 4) begin
                    cycs[cnt] = log_cyc[nlog-1];
                    rows[cnt] = log_row[nlog-1];
                    cnt++;
                end
                nlog = 0;
            end
        end
        check(cnt == nref, "R6 refresh count", cnt, nref);
        for (int k = 1; k < nref; k++) begin
            check(cycs[k] - cycs[k-1] == (RBASE << rs), "R6 refresh interval", cycs[k] - cycs[k-1], RBASE << rs);
            check(rows[k] == k, "R7 refresh row increments", rows[k], k);
        end
    endtask

    // R9: refresh holds off a request that arrives mid-traffic.
    task automatic t_refresh_block;
        int w, a, b, found_ref, last;
        bit seen;
        do_reset(2'd0);
        for (int k = 0; k < NB; k++) do_req(1'b0, k, k + 1, 0, w, a);
        settle(XFER_C + 2);
        seen = 1'b0;
        for (int i = 0; i < 800 && !seen; i++) begin
            b = i % NB;
            nlog = 0;
            do_req(1'b0, b, b + 1, i % 64, w, a);
            if (w > 0) begin
                seen = 1'b1;
                settle(1);
                found_ref = 0;
                for (int k = 0; k < nlog; k++) if (log_op[k] == OP_REF) found_ref = 1;
                last = nlog - 1;
                check(found_ref == 1, "R9 refresh issued while request held", found_ref, 1);
                check(w > ACT_C, "R9 ready held low through refresh", w, ACT_C + 1);
                check(last >= 1 && log_op[last] == OP_RD && log_bank[last] == b, "R9 held request served", log_op[last], OP_RD);
                check(last >= 1 && log_op[last-1] == OP_ACT && log_bank[last-1] == b, "R8 reactivate after refresh", log_op[last-1], OP_ACT);
            end
        end
        check(seen, "R9 stall observed", int'(seen), 1);
    endtask

    initial begin
        t_reset();
        t_closed_then_hit();
        t_occupancy();
        t_refresh_close();
        t_refresh_rate(2'd0, 3);
        t_refresh_rate(2'd2, 2);
        t_refresh_block();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule